// File: doc/BRIEF.md
# Glitch Filter for an Asynchronous Clock Input

This block cleans up a slow external clock or count input before later logic looks for its edges. The raw pin is first brought into the system clock domain by a chain of synchronizer flops. The synchronized level is then sampled only on cycles where a sample enable is active, and a filter turns those samples into a stable output level. Short pulses that the filter does not accept never reach the output.

A two-bit control field sets two things independently. The low bit picks where the sample enable comes from: an internal toggle flop that is active on every second system clock, or a shared channel filter enable that is generated somewhere else. The high bit picks the filter rule. The first rule is two-sample agreement. The second is a saturating up/down integrator with hysteresis.

A new control value does not reset the filter. It takes effect at the next sample enable, and the output keeps its level until then.

Top module: `gf_input_filter`

## Requirements
- R1: The raw input passes through two synchronizer flops. With the channel enable selected and held high, a raw rise that is set up before clock edge E1 shows at the output after edge E4 and not before.
- R2: When ctrl[0]=0, samples are taken on every second system clock and chan_en has no effect. A level held for 8 clocks is accepted, and an integrator that needs 3 samples has not switched after 5 clocks.
- R3: When ctrl[0]=1, a sample is taken only on a clock where chan_en is 1. While chan_en stays 0, the output holds for any raw activity.
- R4: In two-sample mode (ctrl[1]=0), the output takes a new level only when the current sample and the previous sample both equal that level.
- R5: In two-sample mode, a single sample that differs from its neighbours leaves the output unchanged.
- R6: In integration mode (ctrl[1]=1), a 2-bit count steps up on a high sample and down on a low sample. The output goes to 1 when the count reaches 3 and to 0 when it reaches 0, and holds its level in between.
- R7: The integration count saturates at 3 and at 0 and never wraps.
- R8: During and after reset the output is 0, and the stored sample and the count are 0.
- R9: A change on ctrl leaves the output as it is. The new selection governs from the next sample enable onward.
- R10: The internal divide-by-2 enable alternates on every system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 1 | Asynchronous raw input |
| chan_en | input | 1 | Shared channel filter sample enable, one clock wide |
| ctrl | input | 2 | Bit 0: sample source (0 divide-by-2, 1 channel). Bit 1: mode (0 two-sample, 1 integration) |
| filt_out | output | 1 | Filtered level |

## Verification
The hardest case to reach is a mode change that happens while the two filter rules hold different state. The integrator count stands part way, the stored sample is already high, and the output is still low. The bench drives the channel enable directly as single-clock pulses, so the exact number of samples taken is known. It leaves the integrator one step above zero, switches to two-sample mode with no enable active, and checks two things: the output holds, and the very next pulse applies the two-sample rule rather than the integrator rule.

// File: rtl/gf_input_filter_pkg.sv
package gf_input_filter_pkg;

    typedef enum logic {
        SRC_DIV2 = 1'b0,
        SRC_CHAN = 1'b1
    } smp_src_e;

    typedef enum logic {
        MODE_PAIR  = 1'b0,
        MODE_INTEG = 1'b1
    } filt_mode_e;

    typedef struct packed {
        filt_mode_e mode;
        smp_src_e   src;
    } filt_ctrl_t;

    function automatic filt_ctrl_t decode_ctrl(input logic [1:0] c);
        filt_ctrl_t r;
        r.src  = smp_src_e'(c[0]);
        r.mode = filt_mode_e'(c[1]);
        return r;
    endfunction

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/gf_sample_sel.sv
module gf_sample_sel
    import gf_input_filter_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  smp_src_e src,
    input  logic     chan_en,
    output logic     smp_en,
    output logic     div_tog
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign smp_en  = (src == SRC_CHAN) ? chan_en : tog_q;
    assign div_tog = tog_q;
endmodule

// File: rtl/gf_filter_core.sv
module gf_filter_core
    import gf_input_filter_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             din,
    input  filt_mode_e       mode,
    output logic             lvl,
    output logic             prev_smp,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.prev = din;
            if (din && st_q.cnt != CNT_MAX)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (!din && st_q.cnt != CNT_MIN)
                st_d.cnt = st_q.cnt - 1'b1;

            if (mode == MODE_INTEG) begin
                if (st_d.cnt == CNT_MAX)      st_d.out = 1'b1;
                else if (st_d.cnt == CNT_MIN) st_d.out = 1'b0;
            end else begin
                if (din == st_q.prev)         st_d.out = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.out;
    assign prev_smp = st_q.prev;
    assign cnt      = st_q.cnt;
endmodule

// File: rtl/gf_input_filter.sv
module gf_input_filter
    import gf_input_filter_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic       chan_en,
    input  logic [1:0] ctrl,
    output logic       filt_out
);
    filt_ctrl_t       cfg;
    logic             sync_lvl;
    logic             smp_en;
    logic             div_tog;
    logic             prev_smp;
    logic [CNT_W-1:0] int_cnt;

    assign cfg = decode_ctrl(ctrl);

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_lvl)
    );

    gf_sample_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (cfg.src),
        .chan_en(chan_en),
        .smp_en (smp_en),
        .div_tog(div_tog)
    );

    gf_filter_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .din     (sync_lvl),
        .mode    (cfg.mode),
        .lvl     (filt_out),
        .prev_smp(prev_smp),
        .cnt     (int_cnt)
    );
endmodule

// File: rtl/gf_input_filter_chk.sv
module gf_input_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_en,
    input logic [1:0] ctrl,
    input logic       filt_out,
    input logic       sync_lvl,
    input logic       prev_smp,
    input logic [1:0] int_cnt,
    input logic       div_tog
);
    p_hold_without_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !chan_en) |=> $stable(filt_out));

    p_pair_rise_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(filt_out) && !$past(ctrl[1])) |-> ($past(sync_lvl) && $past(prev_smp)));

    p_pair_fall_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(filt_out) && !$past(ctrl[1])) |-> (!$past(sync_lvl) && !$past(prev_smp)));

    p_integ_rise_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(filt_out) && $past(ctrl[1])) |-> (int_cnt == 2'd3));

    p_integ_fall_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(filt_out) && $past(ctrl[1])) |-> (int_cnt == 2'd0));

    p_no_wrap_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cnt == 2'd3) |=> (int_cnt != 2'd0));

    p_no_wrap_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cnt == 2'd0) |=> (int_cnt != 2'd3));

    p_div_alternates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_tog |=> !div_tog);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_clear_r8: assert (!filt_out);
        end
    end
endmodule

bind gf_input_filter gf_input_filter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .ctrl    (ctrl),
    .filt_out(filt_out),
    .sync_lvl(sync_lvl),
    .prev_smp(prev_smp),
    .int_cnt (int_cnt),
    .div_tog (div_tog)
);

// File: tb/gf_input_filter_test.sv
`timescale 1ns/1ps
module gf_input_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b0;
    logic       chan_en = 1'b0;
    logic [1:0] ctrl = 2'b00;
    logic       filt_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gf_input_filter uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
        .chan_en(chan_en), .ctrl(ctrl), .filt_out(filt_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chan_en = 1'b0; raw_in = 1'b0;
        edges(2);
        rst_n = 1'b1;
    endtask

    // set level and let the synchronizer settle
    task automatic drive_raw(input logic v);
        raw_in = v;
        edges(3);
    endtask

    task automatic pulse();
        chan_en = 1'b1;
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; raw_in = 1'b1; ctrl = 2'b00;
        edges(3);
        check(filt_out, 1'b0, "R8 output low in reset");
        do_reset();
        edges(1);
        check(filt_out, 1'b0, "R8 output low after reset");
    endtask

    task automatic t_sync_latency();
        do_reset();
        ctrl = 2'b01; chan_en = 1'b1;
        raw_in = 1'b1;
        edges(3);
        check(filt_out, 1'b0, "R1 not yet after third edge");
        edges(1);
        check(filt_out, 1'b1, "R1 after fourth edge");
        chan_en = 1'b0;
    endtask

    task automatic t_div2();
        do_reset();
        ctrl = 2'b10; chan_en = 1'b0;
        raw_in = 1'b1;
        edges(5);
        check(filt_out, 1'b0, "R2 integrator not full after 5 clocks");
        edges(3);
        check(filt_out, 1'b1, "R2 integrator full after 8 clocks");
        do_reset();
        ctrl = 2'b00; chan_en = 1'b0;
        raw_in = 1'b1;
        edges(8);
        check(filt_out, 1'b1, "R2 pair mode accepts with chan_en low");
    endtask

    task automatic t_chan_gate();
        do_reset();
        ctrl = 2'b01;
        raw_in = 1'b1;
        edges(20);
        check(filt_out, 1'b0, "R3 pair mode no enable");
        ctrl = 2'b11;
        edges(20);
        check(filt_out, 1'b0, "R3 integ mode no enable");
        ctrl = 2'b01;
        pulse(); pulse();
        check(filt_out, 1'b1, "R3 two enables accepted");
    endtask

    task automatic t_pair();
        do_reset();
        ctrl = 2'b01;
        drive_raw(1'b1); pulse();
        check(filt_out, 1'b0, "R4 one high sample");
        pulse();
        check(filt_out, 1'b1, "R4 two high samples");
        drive_raw(1'b0); pulse();
        check(filt_out, 1'b1, "R4 one low sample");
        pulse();
        check(filt_out, 1'b0, "R4 two low samples");
    endtask

    task automatic t_glitch();
        do_reset();
        ctrl = 2'b01;
        drive_raw(1'b1); pulse();
        drive_raw(1'b0); pulse();
        drive_raw(1'b1); pulse();
        check(filt_out, 1'b0, "R5 alternating samples ignored");
        pulse();
        check(filt_out, 1'b1, "R5 agreeing pair accepted");
        drive_raw(1'b0); pulse();
        drive_raw(1'b1); pulse();
        check(filt_out, 1'b1, "R5 single low glitch ignored");
    endtask

    task automatic t_integ();
        do_reset();
        ctrl = 2'b11;
        drive_raw(1'b1);
        pulse(); pulse();
        check(filt_out, 1'b0, "R6 count 2 stays low");
        pulse();
        check(filt_out, 1'b1, "R6 count 3 goes high");
        drive_raw(1'b0);
        pulse(); pulse();
        check(filt_out, 1'b1, "R6 count 1 holds high");
        drive_raw(1'b1); pulse();
        drive_raw(1'b0); pulse();
        check(filt_out, 1'b1, "R6 up then down holds high");
        pulse();
        check(filt_out, 1'b0, "R6 count 0 goes low");
    endtask

    task automatic t_saturate();
        do_reset();
        ctrl = 2'b11;
        drive_raw(1'b1);
        for (int i = 0; i < 6; i++) pulse();
        check(filt_out, 1'b1, "R7 saturated high");
        drive_raw(1'b0);
        pulse(); pulse();
        check(filt_out, 1'b1, "R7 two steps down from max");
        pulse();
        check(filt_out, 1'b0, "R7 third step reaches zero");
        for (int i = 0; i < 5; i++) pulse();
        drive_raw(1'b1);
        pulse(); pulse();
        check(filt_out, 1'b0, "R7 floor held, two up still low");
        pulse();
        check(filt_out, 1'b1, "R7 three up from floor");
    endtask

    task automatic t_mode_switch();
        do_reset();
        ctrl = 2'b11;
        drive_raw(1'b1); pulse();
        ctrl = 2'b01;
        edges(4);
        check(filt_out, 1'b0, "R9 holds until next enable");
        pulse();
        check(filt_out, 1'b1, "R9 pair rule applied on next enable");
        ctrl = 2'b11;
        edges(6);
        check(filt_out, 1'b1, "R9 output kept across switch");
        drive_raw(1'b0); pulse();
        check(filt_out, 1'b1, "R9 integ hysteresis after switch");
    endtask

    initial begin
        t_reset();
        t_sync_latency();
        t_div2();
        t_chan_gate();
        t_pair();
        t_glitch();
        t_integ();
        t_saturate();
        t_mode_switch();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule